// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer With Lock

This block takes one serial bit stream that has already been sampled once per bit in the local clock domain. It turns that stream back into 10-bit parallel words. Each word travels as a 12-bit frame. A 1 opens the frame, the ten payload bits follow with the least significant bit first, and a 0 closes it. The fixed 0-to-1 step between one frame's closing bit and the next frame's opening bit acts as an embedded word clock. The receiver hunts for that boundary by testing one bit phase after another. It declares lock only after the boundary has held for a long unbroken run of frames.

While locked, the block presents each good frame's payload on a parallel word with a one-cycle strobe. It also produces a square-wave recovered word clock and drives an active-low lock flag. The lock flag falls in the same cycle as the first valid word. A single broken frame is tolerated. Two in a row drop lock, and the block then goes back to hunting by itself.

A power-enable input sends the block back to its starting state. An output-enable input blanks the data and the word clock but leaves the lock flag running. High impedance is represented by a flag that marks the outputs as switched off.

Top module: `ecfd_top`

## Requirements
- R1: A frame is 12 bit-times: an opening 1, payload bits 0 through 9 in that order (bit 0 directly after the opening bit), then a closing 0. A delivered `word_out` carries those payload bits at positions 0 to 9.
- R2: While hunting, the block judges a candidate boundary once every 12 bits. When a candidate fails, its run of good frames is reset to zero and the next judgement comes 11 bit-times later, which moves the boundary by one bit.
- R3: Lock needs 80 consecutive good frames. Until then `lock_n` is 1, `word_out` is 0 and `word_vld` is 0.
- R4: `lock_n` falls in the very cycle that `word_vld` first pulses, and that word carries the 80th good frame. While locked, every good frame gives exactly one `word_vld` pulse, one cycle after its closing bit is sampled.
- R5: While locked, one bad frame keeps `lock_n` at 0, gives no `word_vld` pulse, and leaves `word_out` holding the previous word.
- R6: Two consecutive bad frames while locked raise `lock_n` to 1 and clear `word_out`, in the cycle after the second bad closing bit. Hunting then resumes without outside help and lock returns after 80 new good frames.
- R7: While `pwr_up` is 0 the block is held at its start state: `lock_n` is 1, `word_out` is 0, `wclk_out` is 0 and `out_off` is 1. After `pwr_up` returns to 1, the bit in that first cycle is bit 0 of a frame, and acquisition needs 80 fresh good frames.
- R8: While `out_en` is 0, `word_out`, `word_vld` and `wclk_out` are 0 and `out_off` is 1. Framing and `lock_n` carry on unchanged. When `out_en` returns to 1, the current word is shown again without relocking.
- R9: While locked, `wclk_out` is high for 6 cycles and low for 6 cycles of each frame. With `edge_sel` = 1 it goes high in the cycle a word is delivered; with `edge_sel` = 0 it goes low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_up | input | 1 | 0 holds the block powered down and at its start state |
| out_en | input | 1 | 1 enables data and word clock outputs |
| edge_sel | input | 1 | Word clock polarity: 1 data on rising edge, 0 data on falling edge |
| ser_in | input | 1 | Serial bit, one per clock |
| word_out | output | 10 | Recovered payload word |
| word_vld | output | 1 | One-cycle pulse per delivered word |
| wclk_out | output | 1 | Recovered word clock |
| lock_n | output | 1 | 0 while locked |
| out_off | output | 1 | 1 when outputs are treated as high impedance |

## Verification
The hardest situation to reach is the loss and re-acquisition of lock. It needs a long run of good frames, then exactly two broken frames in a row, and then enough further traffic for the phase hunt to circle back to the true boundary. The stimulus sends 80 aligned frames and inserts a lone bad frame, which must not drop lock. It then sends a pair of frames with a wrong opening bit and continues with 200 good frames, so that the hunt can step through the wrong phases and lock again. A behavioural model checks every cycle of this sequence, including the exact cycle in which lock returns.

// File: rtl/ecfd_pkg.sv
package ecfd_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } ecfd_state_e;
endpackage

// File: rtl/ecfd_framer.sv
module ecfd_framer #(
  parameter int DATA_BITS = 10,
  localparam int FRAME_BITS = DATA_BITS + 2,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 ser_in,
  input  logic                 slip,
  output logic                 chk,
  output logic                 frame_ok,
  output logic [DATA_BITS-1:0] payload,
  output logic [PW-1:0]        phase
);
  localparam int HIST = DATA_BITS + 1;
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [HIST-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      hist_q <= '0;
      phase  <= '0;
    end else begin
      hist_q <= {ser_in, hist_q[HIST-1:1]};
      if (phase == LAST) phase <= slip ? PW'(1) : '0;
      else               phase <= phase + PW'(1);
    end
  end

  assign chk      = (phase == LAST);
  assign frame_ok = hist_q[0] & ~ser_in;
  assign payload  = hist_q[DATA_BITS:1];

  // R2
  slip_step_chk: assert property (@(posedge clk) disable iff (clr)
    (chk && slip) |=> (phase == PW'(1)));
endmodule

// File: rtl/ecfd_lock_ctrl.sv
module ecfd_lock_ctrl
  import ecfd_pkg::*;
#(
  parameter int LOCK_FRAMES = 80,
  parameter int MISS_LIMIT  = 2,
  localparam int GW = $clog2(LOCK_FRAMES + 1),
  localparam int MW = $clog2(MISS_LIMIT + 1)
) (
  input  logic clk,
  input  logic clr,
  input  logic chk,
  input  logic frame_ok,
  output logic locked,
  output logic take,
  output logic slip,
  output logic lost
);
  ecfd_state_e st_q;
  logic [GW-1:0] good_q;
  logic [MW-1:0] miss_q;

  always_comb begin
    take = 1'b0;
    slip = 1'b0;
    lost = 1'b0;
    if (chk) begin
      if (st_q == ST_HUNT) begin
        if (frame_ok) take = (good_q == GW'(LOCK_FRAMES - 1));
        else          slip = 1'b1;
      end else begin
        if (frame_ok) take = 1'b1;
        else if (miss_q == MW'(MISS_LIMIT - 1)) begin
          lost = 1'b1;
          slip = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      miss_q <= '0;
    end else if (chk) begin
      if (st_q == ST_HUNT) begin
        if (!frame_ok)  good_q <= '0;
        else if (take) begin
          st_q   <= ST_LOCKED;
          good_q <= '0;
          miss_q <= '0;
        end else        good_q <= good_q + GW'(1);
      end else begin
        if (frame_ok)   miss_q <= '0;
        else if (lost) begin
          st_q   <= ST_HUNT;
          miss_q <= '0;
        end else        miss_q <= miss_q + MW'(1);
      end
    end
  end

  assign locked = (st_q == ST_LOCKED);

  // R5
  single_miss_hold_chk: assert property (@(posedge clk) disable iff (clr)
    ((MISS_LIMIT > 1) && locked && chk && !frame_ok && miss_q == '0) |=> locked);

  // R6
  drop_cause_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(locked) |-> ($past(clr) || $past(chk && !frame_ok)));

  // R2
  hunt_reset_chk: assert property (@(posedge clk) disable iff (clr)
    (!locked && chk && !frame_ok) |=> (good_q == '0 && !locked));
endmodule

// File: rtl/ecfd_out_stage.sv
module ecfd_out_stage #(
  parameter int DATA_BITS = 10,
  localparam int FRAME_BITS = DATA_BITS + 2,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 take,
  input  logic                 lost,
  input  logic                 locked,
  input  logic [DATA_BITS-1:0] payload,
  input  logic [PW-1:0]        phase,
  input  logic                 out_en,
  input  logic                 pwr_up,
  input  logic                 edge_sel,
  output logic [DATA_BITS-1:0] word_out,
  output logic                 word_vld,
  output logic                 wclk_out,
  output logic                 out_off
);
  localparam logic [PW-1:0] HALF = PW'(FRAME_BITS / 2);

  logic [DATA_BITS-1:0] word_q;
  logic                 vld_q;
  logic                 enable;

  always_ff @(posedge clk) begin
    if (clr) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take;
      if (take)      word_q <= payload;
      else if (lost) word_q <= '0;
    end
  end

  assign enable   = out_en & pwr_up;
  assign word_out = enable ? word_q : '0;
  assign word_vld = enable & vld_q;
  assign wclk_out = enable & locked & ((phase < HALF) == edge_sel);
  assign out_off  = ~enable;

  // R3
  quiet_unlocked_chk: assert property (@(posedge clk) disable iff (clr)
    !locked |-> (word_q == '0 && !vld_q));

  // R4
  lock_with_word_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(locked) |-> vld_q);
endmodule

// File: rtl/ecfd_top.sv
module ecfd_top #(
  parameter int DATA_BITS   = 10,
  parameter int LOCK_FRAMES = 80,
  parameter int MISS_LIMIT  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwr_up,
  input  logic                 out_en,
  input  logic                 edge_sel,
  input  logic                 ser_in,
  output logic [DATA_BITS-1:0] word_out,
  output logic                 word_vld,
  output logic                 wclk_out,
  output logic                 lock_n,
  output logic                 out_off
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int PW = $clog2(FRAME_BITS);

  logic                 clr;
  logic                 chk, frame_ok, slip, take, lost, locked;
  logic [DATA_BITS-1:0] payload;
  logic [PW-1:0]        phase;

  assign clr = rst | ~pwr_up;

  ecfd_framer #(.DATA_BITS(DATA_BITS)) u_framer (
    .clk(clk), .clr(clr), .ser_in(ser_in), .slip(slip),
    .chk(chk), .frame_ok(frame_ok), .payload(payload), .phase(phase)
  );

  ecfd_lock_ctrl #(.LOCK_FRAMES(LOCK_FRAMES), .MISS_LIMIT(MISS_LIMIT)) u_lock (
    .clk(clk), .clr(clr), .chk(chk), .frame_ok(frame_ok),
    .locked(locked), .take(take), .slip(slip), .lost(lost)
  );

  ecfd_out_stage #(.DATA_BITS(DATA_BITS)) u_out (
    .clk(clk), .clr(clr), .take(take), .lost(lost), .locked(locked),
    .payload(payload), .phase(phase), .out_en(out_en), .pwr_up(pwr_up),
    .edge_sel(edge_sel), .word_out(word_out), .word_vld(word_vld),
    .wclk_out(wclk_out), .out_off(out_off)
  );

  assign lock_n = ~locked;

  // R7
  powerdown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_up |=> (lock_n && !word_vld && !wclk_out));
endmodule

// File: tb/sim_ecfd_top.sv
module sim_ecfd_top;
  logic clk = 1'b0;
  logic rst = 1'b1, pwr_up = 1'b1, out_en = 1'b1, edge_sel = 1'b1, ser_in = 1'b0;
  logic [9:0] word_out;
  logic word_vld, wclk_out, lock_n, out_off;

  always #2.5 clk = ~clk;

  ecfd_top u0 (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .out_en(out_en), .edge_sel(edge_sel),
    .ser_in(ser_in), .word_out(word_out), .word_vld(word_vld),
    .wclk_out(wclk_out), .lock_n(lock_n), .out_off(out_off)
  );

  int checks = 0, fails = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit   hist[$];
  int   m_pos = 0, m_good = 0, m_miss = 0;
  bit   m_lock = 0, m_vld = 0;
  logic [9:0] m_word = '0;

  always @(posedge clk) begin
    bit ok;
    logic [9:0] pl;
    if (rst || !pwr_up) begin
      hist.delete();
      m_pos = 0; m_good = 0; m_miss = 0; m_lock = 0; m_vld = 0; m_word = '0;
    end else begin
      hist.push_back(ser_in);
      if (hist.size() > 12) void'(hist.pop_front());
      m_vld = 0;
      if (m_pos == 11) begin
        ok = (hist[0] == 1'b1) && (hist[11] == 1'b0);
        for (int i = 0; i < 10; i++) pl[i] = hist[i+1];
        if (!m_lock) begin
          if (ok) begin
            m_good++;
            if (m_good == 80) begin
              m_lock = 1; m_good = 0; m_miss = 0; m_word = pl; m_vld = 1;
            end
            m_pos = 0;
          end else begin
            m_good = 0; m_pos = 1;
          end
        end else begin
          if (ok) begin
            m_miss = 0; m_word = pl; m_vld = 1; m_pos = 0;
          end else begin
            m_miss++;
            if (m_miss == 2) begin
              m_lock = 0; m_miss = 0; m_word = '0; m_pos = 1;
            end else m_pos = 0;
          end
        end
      end else m_pos++;
    end
    #1;
    if (!rst) begin
      bit en;
      en = out_en && pwr_up;
      check("R1 word_out model", word_out, en ? m_word : 10'h0);
      check("R4 word_vld model", word_vld, en && m_vld);
      check("R3 lock_n model", lock_n, !m_lock);
      check("R9 wclk_out model", wclk_out, en && m_lock && ((m_pos < 6) == edge_sel));
      check("R8 out_off model", out_off, !en);
    end
  end

  // stimulus
  logic [15:0] lf = 16'hACE1;
  logic [9:0]  last_d = '0;

  task automatic drive_bit(input logic b);
    ser_in = b;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [9:0] d, input logic st, input logic sp);
    drive_bit(st);
    for (int i = 0; i < 10; i++) drive_bit(d[i]);
    drive_bit(sp);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic good_frames(input int n);
    for (int k = 0; k < n; k++) begin
      lf = lfsr_next(lf);
      last_d = lf[9:0];
      send_frame(last_d, 1'b1, 1'b0);
    end
  endtask

  task automatic run_all();
    logic [9:0] held;
    repeat (3) @(negedge clk);
    check("R3 reset lock_n", lock_n, 1'b1);
    check("R3 reset word_out", word_out, 10'h0);
    check("R3 reset word_vld", word_vld, 1'b0);
    rst = 1'b0;
    // acquisition from aligned start
    good_frames(79);
    check("R3 unlocked after 79 frames", lock_n, 1'b1);
    check("R3 no data before lock", word_out, 10'h0);
    good_frames(1);
    check("R4 lock_n low with first word", lock_n, 1'b0);
    check("R4 first word_vld", word_vld, 1'b1);
    check("R1 first word payload", word_out, last_d);
    check("R9 wclk high at delivery (rising)", wclk_out, 1'b1);
    for (int k = 0; k < 3; k++) begin
      good_frames(1);
      check("R1 locked payload", word_out, last_d);
      check("R4 locked word_vld", word_vld, 1'b1);
    end
    drive_bit(1'b1);
    check("R4 strobe lasts one cycle", word_vld, 1'b0);
    for (int i = 0; i < 10; i++) drive_bit(1'b0);
    drive_bit(1'b0);
    edge_sel = 1'b0;
    good_frames(1);
    check("R9 wclk low at delivery (falling)", wclk_out, 1'b0);
    edge_sel = 1'b1;
    // single bad frame
    held = last_d;
    send_frame(10'h155, 1'b1, 1'b1);
    check("R5 lock kept after one bad frame", lock_n, 1'b0);
    check("R5 no strobe for bad frame", word_vld, 1'b0);
    check("R5 word held", word_out, held);
    good_frames(1);
    check("R5 next good word", word_out, last_d);
    // two bad frames
    send_frame(10'h0F0, 1'b0, 1'b0);
    check("R6 lock kept after first of two", lock_n, 1'b0);
    send_frame(10'h00F, 1'b0, 1'b0);
    check("R6 lock lost after two bad", lock_n, 1'b1);
    check("R6 word cleared on loss", word_out, 10'h0);
    good_frames(200);
    check("R6 relocked automatically", lock_n, 1'b0);
    check("R6 relocked payload", word_out, last_d);
    // output enable
    out_en = 1'b0;
    good_frames(1);
    check("R8 data blanked", word_out, 10'h0);
    check("R8 strobe blanked", word_vld, 1'b0);
    check("R8 wclk blanked", wclk_out, 1'b0);
    check("R8 out_off set", out_off, 1'b1);
    check("R8 lock_n still active", lock_n, 1'b0);
    out_en = 1'b1;
    #0.5;
    check("R8 current word shown again", word_out, last_d);
    good_frames(1);
    check("R8 strobe resumes", word_vld, 1'b1);
    check("R8 no relock needed", word_out, last_d);
    // power down
    pwr_up = 1'b0;
    repeat (20) drive_bit(1'b1);
    check("R7 lock_n high in power-down", lock_n, 1'b1);
    check("R7 out_off in power-down", out_off, 1'b1);
    check("R7 word_out zero in power-down", word_out, 10'h0);
    check("R7 wclk zero in power-down", wclk_out, 1'b0);
    pwr_up = 1'b1;
    good_frames(79);
    check("R7 fresh acquisition still unlocked", lock_n, 1'b1);
    good_frames(1);
    check("R7 relock after 80 fresh frames", lock_n, 1'b0);
    check("R7 payload after power-up", word_out, last_d);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit wd;
    wd = 0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule